// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port that sits behind a plain byte-wide register bus. The bus has an address, a write enable, write data and combinational read data. Inside, the port holds two registers: a direction register and an output data register. They drive the pin output-value lines and the pin output-enable lines directly. External pin levels pass through a two-flop synchronizer before any read sees them.

Data accesses go through an address window. Inside that window the address itself carries a per-pin mask, so one bus write can change any subset of pins and leave the others alone. Software therefore never needs a read-modify-write sequence, even when several agents share the port. A data write only takes hold on pins that are already outputs, so a pin must be made an output before the value written to it sticks.

The bus has no handshake: a write completes at the clock edge where the write enable is high, and read data follows the address in the same cycle. No valid/ready stream exists here, so no back-pressure rules apply.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction register and the output data register are both zero, so pin_oe and pin_out are 0 and every pin is an input.
- R2: A write to offset 0x400 (address bit 10 set, bits 9:0 clear) loads the direction register at that clock edge. Bit n set makes pin n an output, and pin_oe equals the register. A read of 0x400 returns exactly the last value written.
- R3: A write with address bit 10 clear is a data write, and address bit n+2 is the mask bit for pin n. At the write edge, pin_out bit n takes write-data bit n when its mask bit is set and pin n is an output. All other pin_out bits keep their value.
- R4: A data write to a pin whose direction bit is clear has no effect on pin_out, even when its mask bit is set.
- R5: A data read (address bit 10 clear) returns zero in every bit whose mask bit is clear.
- R6: In a data read, a masked bit of a pin that is an output returns the value on pin_out.
- R7: In a data read, a masked bit of a pin that is an input returns the external level after two synchronizer flops. A change on pin_in therefore becomes visible after the second rising clock edge.
- R8: Any address with bit 10 set and bits 9:0 not all zero is unmapped. Writes to it change nothing and reads from it return zero. Address bits 1:0 are ignored in the data window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 11 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Driven value for each pin |
| pin_oe | output | 8 | Output enable for each pin, 1 = drive |

## Verification
The assertions check on every cycle that:
- a direction write lands one edge later;
- a data write changes only the pins that are both masked and outputs;
- an idle or unmapped cycle leaves both registers untouched;
- an unmasked read bit is always zero.

Only the bench scenarios can show the two-edge latency of an input change, the mixed read-back of output and input pins under one mask, and the order dependence in which a value written before the direction change is lost. The bench shows these by comparing against a reference model on every clock.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [PINS+2:0]  addr,
  output acc_kind_e        kind,
  output logic [PINS-1:0]  mask
);
  localparam int SEL_BIT = PINS + 2;

  logic            win_hi;
  logic [PINS+1:0] low_part;

  assign win_hi   = addr[SEL_BIT];
  assign low_part = addr[SEL_BIT-1:0];

  always_comb begin
    if (!win_hi) begin
      kind = ACC_DATA;
      mask = addr[PINS+1:2];
    end else begin
      kind = (low_part == '0) ? ACC_DIR : ACC_NONE;
      mask = '0;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] raw_in,
  output logic [PINS-1:0] sync_out
);
  logic [STAGES-1:0][PINS-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= raw_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mask_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  acc_kind_e       kind,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);
  logic [PINS-1:0] upd_bits;

  assign upd_bits = (wr_en && kind == ACC_DATA) ? (mask & dir_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dir_q <= '0;
    else if (wr_en && kind == ACC_DIR) dir_q <= wdata;
  end

  for (genvar b = 0; b < PINS; b++) begin : g_out_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           out_q[b] <= 1'b0;
      else if (upd_bits[b]) out_q[b] <= wdata[b];
    end
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == ACC_DIR) |=> (dir_q == $past(wdata)));

  assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == ACC_DATA) |=>
      (((out_q ^ $past(wdata)) & $past(mask & dir_q)) == '0));

  assert_input_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == ACC_DATA) |=>
      (((out_q ^ $past(out_q)) & ~$past(mask & dir_q)) == '0));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && kind != ACC_NONE) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS+2:0] bus_addr,
  input  logic            bus_wr_en,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  acc_kind_e       acc_kind;
  logic [PINS-1:0] acc_mask;
  logic [PINS-1:0] dir_r;
  logic [PINS-1:0] out_r;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] live_val;

  gpio_addr_decode #(.PINS(PINS)) dec_i (
    .addr (bus_addr),
    .kind (acc_kind),
    .mask (acc_mask)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pin_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.PINS(PINS)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr_en),
    .kind  (acc_kind),
    .mask  (acc_mask),
    .wdata (bus_wdata),
    .dir_q (dir_r),
    .out_q (out_r)
  );

  assign live_val = (dir_r & out_r) | (~dir_r & pin_sync);

  always_comb begin
    unique case (acc_kind)
      ACC_DATA: bus_rdata = acc_mask & live_val;
      ACC_DIR:  bus_rdata = dir_r;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_r;
  assign pin_oe  = dir_r;

  assert_unmasked_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[PINS+2] |-> ((bus_rdata & ~bus_addr[PINS+1:2]) == '0));

  assert_output_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[PINS+2] |->
      (((bus_rdata ^ pin_out) & pin_oe & bus_addr[PINS+1:2]) == '0));
endmodule

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
  localparam int PINS = 8;
  localparam int AW   = PINS + 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr_en = 1'b0;
  logic [PINS-1:0] bus_wdata = '0;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [PINS-1:0] m_dir = '0, m_out = '0, m_s1 = '0, m_s2 = '0;

  always #10 clk = ~clk;

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check8(input logic [PINS-1:0] act, input logic [PINS-1:0] exp,
                        input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] model_rd(input logic [AW-1:0] a);
    if (!a[AW-1]) return a[PINS+1:2] & ((m_dir & m_out) | (~m_dir & m_s2));
    else if (a[AW-2:0] == '0) return m_dir;
    else return '0;
  endfunction

  // Drive one cycle, compare every output against the model, then advance it.
  task automatic step(input logic [AW-1:0] a, input logic we,
                      input logic [PINS-1:0] wd, input logic [PINS-1:0] pins);
    logic [PINS-1:0] upd;
    @(negedge clk);
    bus_addr = a; bus_wr_en = we; bus_wdata = wd; pin_in = pins;
    #1;
    check8(pin_oe, m_dir, "R2 pin_oe");
    check8(pin_out, m_out, "R3 pin_out");
    if (!a[AW-1])           check8(bus_rdata, model_rd(a), "R5 R6 R7 data read");
    else if (a[AW-2:0] == '0) check8(bus_rdata, model_rd(a), "R2 dir read");
    else                    check8(bus_rdata, model_rd(a), "R8 unmapped read");
    @(posedge clk);
    upd = (we && !a[AW-1]) ? (a[PINS+1:2] & m_dir) : '0;
    m_out = (m_out & ~upd) | (wd & upd);
    if (we && a[AW-1] && a[AW-2:0] == '0) m_dir = wd;
    m_s2 = m_s1;
    m_s1 = pins;
  endtask

  function automatic logic [AW-1:0] dat_a(input logic [PINS-1:0] m);
    return {1'b0, m, 2'b00};
  endfunction

  localparam logic [AW-1:0] DIR_A = 11'h400;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check8(pin_oe, 8'h00, "R1 reset dir");
    check8(pin_out, 8'h00, "R1 reset out");

    // R7: input level appears after two edges
    step(dat_a(8'hFF), 0, 8'h00, 8'hA5);
    step(dat_a(8'hFF), 0, 8'h00, 8'hA5);
    step(dat_a(8'hFF), 0, 8'h00, 8'hA5);
    check8(bus_rdata, 8'hA5, "R7 synced input");

    // R4: write while all pins are inputs
    step(dat_a(8'hFF), 1, 8'hFF, 8'hA5);
    step(dat_a(8'h0F), 0, 8'h00, 8'hA5);
    check8(pin_out, 8'h00, "R4 write to inputs ignored");

    // R2: set low nibble as outputs and read back
    step(DIR_A, 1, 8'h0F, 8'hA5);
    step(DIR_A, 0, 8'h00, 8'hA5);
    check8(bus_rdata, 8'h0F, "R2 dir readback");

    // R3: masked write hits bits 0 and 2 only
    step(dat_a(8'h05), 1, 8'hFF, 8'hA5);
    step(dat_a(8'h30), 1, 8'hFF, 8'hA5);
    step(dat_a(8'hFF), 0, 8'h00, 8'h5A);
    check8(pin_out, 8'h05, "R3 masked write result");
    check8(bus_rdata, 8'hA5, "R6 R7 mixed read");

    // R8: unmapped write ignored, read zero
    step(11'h404, 1, 8'h00, 8'h5A);
    step(11'h404, 0, 8'h00, 8'h5A);
    check8(bus_rdata, 8'h00, "R8 unmapped read zero");
    check8(pin_oe, 8'h0F, "R8 dir untouched");

    // R5: unmasked bits read zero, bits 1:0 of address ignored
    step(11'h006, 0, 8'h00, 8'hFF);
    check8(bus_rdata, 8'h01, "R5 single mask read");

    // R3: all outputs, walk single bits
    step(DIR_A, 1, 8'hFF, 8'h00);
    for (int i = 0; i < PINS; i++) step(dat_a(8'(1 << i)), 1, 8'hFF, 8'h00);
    step(dat_a(8'h81), 1, 8'h00, 8'h00);
    step(dat_a(8'hFF), 0, 8'h00, 8'h00);
    check8(pin_out, 8'h7E, "R3 walk result");

    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6)       a = {1'b0, 8'($urandom), 2'($urandom)};
      else if (sel < 8)  a = DIR_A;
      else               a = {1'b1, 10'($urandom_range(1, 1023))};
      step(a, 1'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule